// File: doc/BRIEF.md
# Synchronised Six-Channel LED Dimming Generator

This block produces the on/off gate and an 8-bit current code for six LED current sinks. All channels share one period counter, so every channel that dims by duty cycle switches on at the same point in the period. The duty value of each channel is latched only when a new period begins.

Each channel takes one of three sources. The first is duty-cycle dimming combined with a current level. The second is current level only, with the output always on. The third is a level supplied by an external pattern engine. A group override sends all six channels to the pattern engine.

The shared counter has four ways of running:
- a plain 12-bit count at a low rate;
- the same count at twice that rate;
- a hybrid 8+4 mode, in which a short coarse period is dithered across a frame of periods;
- a restart on an external sync pulse, so that several blocks can be cascaded.

A software run bit and per-channel enables gate the outputs. They leave the configuration untouched.

Top module: `led_pwm_array`

## Requirements
- R1: Reset clears the period counter, the prescale phase and every latched duty to 0. A channel in duty mode therefore keeps its gate low until the first period boundary after reset.
- R2: In 12-bit operation a duty-mode channel's gate is high exactly while the counter is less than the latched duty. Duty 0 never turns it on, and duty 2^DUTY_W-1 turns it on for all counts except the last.
- R3: The 2-bit mode field of channel c is mode_i[2c+1:2c]. The value 00 selects duty dimming, 01 selects the pattern level, and 10 or 11 select current level only.
- R4: In current-level-only mode the gate stays high in every cycle while the channel is active.
- R5: While group_pat_i is 1, every mode field is ignored and all channels take the pattern source: gate high, with level_o equal to pat_level_i.
- R6: In duty and current-only modes, level_o of a channel equals (gcc_i*cl)>>6 (8 bits). In pattern mode it equals the channel's pat_level_i.
- R7: A channel is active only when run_i=1 and its en_i bit is 1. An inactive channel drives gate 0 and level 0. Latched duties and the counter keep running, so clearing run_i loses no state.
- R8: rate_sel_i=00 advances the counter every second clock; 01 advances it every clock. The period in both cases is 2^DUTY_W counts.
- R9: With rate_sel_i[1]=1 (hybrid), the lower DUTY_W-FRAC_W counter bits form the coarse period and the upper FRAC_W bits index the frame. The gate is high while coarse < duty[DUTY_W-1:FRAC_W] + (frame < duty[FRAC_W-1:0]).
- R10: If group_pat_i is 1 or any channel selects mode 01, the counter runs at the low rate whatever rate_sel_i says.
- R11: A channel's duty is latched only in the cycle that enters a period start (counter 0 with phase 0, or coarse count 0 in hybrid), or on a sync restart. Changes to duty_i at any other time take effect at the next boundary.
- R12: In slave mode (master_i=0) a sync_i pulse forces the counter and phase to 0 on the next clock, and sync_o stays 0. In master mode sync_i is ignored, and sync_o is high in every cycle that is a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Software run bit (0 forces all outputs off) |
| group_pat_i | input | 1 | Route every channel to the pattern source |
| rate_sel_i | input | 2 | Counter rate and resolution select |
| master_i | input | 1 | 1 = emit sync, 0 = follow sync_i |
| sync_i | input | 1 | Restart pulse in slave mode |
| sync_o | output | 1 | Period-start pulse in master mode |
| en_i | input | NUM_CH | Per-channel output enable |
| mode_i | input | 2*NUM_CH | Per-channel source field |
| duty_i | input | DUTY_W*NUM_CH | Per-channel duty value |
| cl_i | input | 8*NUM_CH | Per-channel current level |
| gcc_i | input | 6 | Global current scale |
| pat_level_i | input | 8*NUM_CH | Per-channel pattern-engine level |
| gate_o | output | NUM_CH | Per-channel sink on/off gate |
| level_o | output | 8*NUM_CH | Per-channel current code |

## Verification
The bench builds the block with DUTY_W=6 and FRAC_W=2. The low-rate period is then 128 clocks and the hybrid frame is four 16-count periods, so every rate, the duty extremes 0 and 63, and complete dither frames run many times within a short run. These values also let mid-period duty changes and sync restarts be placed at chosen counts. Six channels keep all three source modes and the enable mask live at the same time.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  localparam int LVL_W = 8;
  localparam int GCC_W = 6;

  typedef enum logic [1:0] {SRC_PWM, SRC_PAT, SRC_CUR} src_e;

  function automatic src_e decode_src(input logic [1:0] m, input logic grp);
    if (grp) return SRC_PAT;
    case (m)
      2'b00:   return SRC_PWM;
      2'b01:   return SRC_PAT;
      default: return SRC_CUR;
    endcase
  endfunction
endpackage

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase #(
  parameter int DUTY_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rate_sel_i,
  input  logic              force_low_i,
  input  logic              master_i,
  input  logic              sync_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic              hyb_o,
  output logic              start_o,
  output logic              load_o
);
  localparam int CW = DUTY_W - FRAC_W;

  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic              pre_q, pre_d;
  logic              dbl, restart;

  assign hyb_o   = rate_sel_i[1] & ~force_low_i;
  assign dbl     = (rate_sel_i == 2'b01) & ~force_low_i;
  assign restart = ~master_i & sync_i;

  always_comb begin
    cnt_d = cnt_q;
    pre_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (hyb_o || dbl) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      pre_d = ~pre_q;
      if (pre_q) cnt_d = cnt_q + 1'b1;
    end
  end

  assign start_o = hyb_o ? (cnt_q[CW-1:0] == '0) : ((cnt_q == '0) && !pre_q);
  assign load_o  = hyb_o ? (cnt_d[CW-1:0] == '0) : ((cnt_d == '0) && !pre_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/led_pwm_chan.sv
module led_pwm_chan
  import led_pwm_pkg::*;
#(
  parameter int DUTY_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic              hyb_i,
  input  logic              load_i,
  input  logic              active_i,
  input  logic              grp_i,
  input  logic [1:0]        mode_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [LVL_W-1:0]  cl_i,
  input  logic [GCC_W-1:0]  gcc_i,
  input  logic [LVL_W-1:0]  pat_i,
  output logic              gate_o,
  output logic [LVL_W-1:0]  level_o
);
  localparam int CW = DUTY_W - FRAC_W;

  logic [DUTY_W-1:0]        duty_q;
  logic [CW:0]              coarse_lim;
  logic                     extra, pwm_on, src_on;
  logic [LVL_W+GCC_W-1:0]   prod;
  logic [LVL_W-1:0]         lvl;
  src_e                     src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (load_i) duty_q <= duty_i;
  end

  // dither: one extra coarse count in the first frac periods of each frame
  assign extra      = cnt_i[DUTY_W-1:CW] < duty_q[FRAC_W-1:0];
  assign coarse_lim = {1'b0, duty_q[DUTY_W-1:FRAC_W]} + {{CW{1'b0}}, extra};
  assign pwm_on     = hyb_i ? ({1'b0, cnt_i[CW-1:0]} < coarse_lim) : (cnt_i < duty_q);

  assign prod = gcc_i * cl_i;
  assign src  = decode_src(mode_i, grp_i);

  always_comb begin
    case (src)
      SRC_PWM: begin src_on = pwm_on; lvl = prod[LVL_W+GCC_W-1:GCC_W]; end
      SRC_PAT: begin src_on = 1'b1;   lvl = pat_i; end
      default: begin src_on = 1'b1;   lvl = prod[LVL_W+GCC_W-1:GCC_W]; end
    endcase
  end

  assign gate_o  = active_i & src_on;
  assign level_o = active_i ? lvl : '0;
endmodule

// File: rtl/led_pwm_array.sv
module led_pwm_array
  import led_pwm_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DUTY_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic                     group_pat_i,
  input  logic [1:0]               rate_sel_i,
  input  logic                     master_i,
  input  logic                     sync_i,
  output logic                     sync_o,
  input  logic [NUM_CH-1:0]        en_i,
  input  logic [2*NUM_CH-1:0]      mode_i,
  input  logic [DUTY_W*NUM_CH-1:0] duty_i,
  input  logic [LVL_W*NUM_CH-1:0]  cl_i,
  input  logic [GCC_W-1:0]         gcc_i,
  input  logic [LVL_W*NUM_CH-1:0]  pat_level_i,
  output logic [NUM_CH-1:0]        gate_o,
  output logic [LVL_W*NUM_CH-1:0]  level_o
);
  logic [DUTY_W-1:0] cnt;
  logic              hyb, period_start, load;
  logic [NUM_CH-1:0] pat_sel;
  logic              force_low;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign pat_sel[c] = (mode_i[2*c +: 2] == 2'b01);
  end
  assign force_low = group_pat_i | (|pat_sel);

  led_pwm_timebase #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_sel_i(rate_sel_i),
    .force_low_i(force_low), .master_i(master_i), .sync_i(sync_i),
    .cnt_o(cnt), .hyb_o(hyb), .start_o(period_start), .load_o(load)
  );

  assign sync_o = master_i & period_start;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    led_pwm_chan #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .hyb_i(hyb), .load_i(load),
      .active_i(run_i & en_i[c]), .grp_i(group_pat_i), .mode_i(mode_i[2*c +: 2]),
      .duty_i(duty_i[DUTY_W*c +: DUTY_W]), .cl_i(cl_i[LVL_W*c +: LVL_W]),
      .gcc_i(gcc_i), .pat_i(pat_level_i[LVL_W*c +: LVL_W]),
      .gate_o(gate_o[c]), .level_o(level_o[LVL_W*c +: LVL_W])
    );
  end
endmodule

// File: rtl/led_pwm_array_chk.sv
module led_pwm_array_chk #(
  parameter int NUM_CH = 6,
  parameter int DUTY_W = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                run_i,
  input logic                group_pat_i,
  input logic                master_i,
  input logic                sync_i,
  input logic                sync_o,
  input logic [NUM_CH-1:0]   en_i,
  input logic [1:0]          mode0_i,
  input logic [7:0]          pat0_i,
  input logic [NUM_CH-1:0]   gate_o,
  input logic [7:0]          level0_o,
  input logic [DUTY_W-1:0]   cnt_i
);
  p_gate_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (gate_o == '0));
  p_level_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (level0_o == '0));
  p_slave_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !sync_o);
  p_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && sync_i) |=> (cnt_i == '0));
  p_cur_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i[0] && !group_pat_i && mode0_i[1]) |-> gate_o[0]);
  p_group_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i[0] && group_pat_i) |-> (gate_o[0] && level0_o == pat0_i));
endmodule

bind led_pwm_array led_pwm_array_chk #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .group_pat_i(group_pat_i),
  .master_i(master_i), .sync_i(sync_i), .sync_o(sync_o), .en_i(en_i),
  .mode0_i(mode_i[1:0]), .pat0_i(pat_level_i[7:0]), .gate_o(gate_o),
  .level0_o(level_o[7:0]), .cnt_i(cnt)
);

// File: tb/sim_led_pwm_array.sv
`timescale 1ns/1ps
module sim_led_pwm_array;
  localparam int NC = 6;
  localparam int DW = 6;
  localparam int FW = 2;
  localparam int CW = DW - FW;

  logic clk = 0, rst_n = 0;
  logic run = 0, grp = 0, master = 0, sync_in = 0;
  logic [1:0] rate = 0;
  logic [5:0] gcc = 0;
  logic [NC-1:0] en = '1;
  int duty[NC], cl[NC], pat[NC], mode[NC];
  logic [2*NC-1:0] mode_v;
  logic [DW*NC-1:0] duty_v;
  logic [8*NC-1:0] cl_v, pat_v, level;
  logic [NC-1:0] gate;
  logic sync_out;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  int m_cnt = 0, m_pre = 0;
  int m_duty[NC];

  always #10 clk = ~clk;

  always_comb
    for (int c = 0; c < NC; c++) begin
      mode_v[2*c +: 2] = mode[c][1:0];
      duty_v[DW*c +: DW] = duty[c][DW-1:0];
      cl_v[8*c +: 8] = cl[c][7:0];
      pat_v[8*c +: 8] = pat[c][7:0];
    end

  led_pwm_array #(.NUM_CH(NC), .DUTY_W(DW), .FRAC_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .group_pat_i(grp), .rate_sel_i(rate),
    .master_i(master), .sync_i(sync_in), .sync_o(sync_out), .en_i(en),
    .mode_i(mode_v), .duty_i(duty_v), .cl_i(cl_v), .gcc_i(gcc),
    .pat_level_i(pat_v), .gate_o(gate), .level_o(level)
  );

  function automatic bit m_force();
    bit f = grp;
    for (int c = 0; c < NC; c++) if (mode[c] == 1) f = 1;
    return f;
  endfunction
  function automatic bit m_hyb();  return rate[1] && !m_force(); endfunction
  function automatic bit m_fast(); return m_hyb() || (rate == 2'b01 && !m_force()); endfunction
  function automatic bit m_start(int cn, int pr);
    if (m_hyb()) return (cn % (1 << CW)) == 0;
    return cn == 0 && pr == 0;
  endfunction

  // reference update at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0;
      for (int c = 0; c < NC; c++) m_duty[c] = 0;
    end else begin
      int nc, np;
      np = 0; nc = m_cnt;
      if (!master && sync_in) nc = 0;
      else if (m_fast()) nc = (m_cnt + 1) % (1 << DW);
      else begin
        np = 1 - m_pre;
        if (m_pre == 1) nc = (m_cnt + 1) % (1 << DW);
      end
      if (m_start(nc, np))
        for (int c = 0; c < NC; c++) m_duty[c] = duty[c];
      m_cnt = nc; m_pre = np;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    for (int c = 0; c < NC; c++) begin
      int em, on, lv, act;
      em = grp ? 1 : (mode[c] == 0 ? 0 : (mode[c] == 1 ? 1 : 2));
      act = run && en[c];
      if (m_hyb()) begin
        int crs, frm;
        crs = m_cnt % (1 << CW); frm = m_cnt / (1 << CW);
        on = crs < (m_duty[c] / (1 << FW)) + ((frm < (m_duty[c] % (1 << FW))) ? 1 : 0);
      end else on = m_cnt < m_duty[c];
      if (em != 0) on = 1;
      lv = (em == 1) ? pat[c] : (gcc * cl[c]) / 64;
      check(tag, $sformatf("gate ch%0d", c), gate[c], act ? on : 0);
      check(tag, $sformatf("level ch%0d", c), level[8*c +: 8], act ? lv : 0);
    end
    check(tag, "sync_o", sync_out, master && m_start(m_cnt, m_pre));
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_all(int md, int g);
    for (int c = 0; c < NC; c++) mode[c] = md;
    gcc = g[5:0];
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      duty[c] = 0; cl[c] = 255; pat[c] = 16 * c + 3; mode[c] = 0;
    end
    set_all(0, 63);
    run = 1;
    cyc(2);
    // R1: outputs during reset with zero duties
    for (int c = 0; c < NC; c++) check("R1", "reset gate", gate[c], 0);
    check("R1", "reset sync_o", sync_out, 0);
    duty[0] = 0; duty[1] = 1; duty[2] = 17; duty[3] = 32; duty[4] = 63; duty[5] = 40;
    rst_n = 1;
    tag = "R1"; cyc(100);
    tag = "R2"; cyc(300);
    tag = "R11"; duty[2] = 50; duty[3] = 5; cyc(7); duty[2] = 9; cyc(250);
    tag = "R8"; rate = 2'b01; cyc(200);
    rate = 2'b00; cyc(140);
    tag = "R9"; rate = 2'b10;
    duty[0] = 5; duty[1] = 6; duty[2] = 7; duty[3] = 63; duty[4] = 1; duty[5] = 2;
    cyc(300);
    tag = "R10"; mode[5] = 1; cyc(200); mode[5] = 0;
    rate = 2'b11; cyc(80);
    tag = "R3"; rate = 2'b00;
    mode[0] = 0; mode[1] = 1; mode[2] = 2; mode[3] = 3; mode[4] = 0; mode[5] = 1;
    gcc = 40; cl[0] = 200; cl[2] = 77; cl[3] = 1; cyc(150);
    tag = "R4"; set_all(2, 63); cyc(60); set_all(3, 1); cyc(40);
    tag = "R6"; set_all(0, 63);
    for (int c = 0; c < NC; c++) cl[c] = 37 * c + 20;
    cyc(80); gcc = 17; cyc(40); gcc = 0; cyc(20); gcc = 63;
    tag = "R5"; mode[0] = 2; mode[1] = 0; grp = 1; rate = 2'b01; cyc(100); grp = 0; set_all(0, 63);
    tag = "R7"; en = 6'b101010; cyc(130); run = 0; cyc(70); run = 1; en = '1; cyc(130);
    tag = "R12"; rate = 2'b01; master = 0;
    cyc(13); sync_in = 1; cyc(1); sync_in = 0; cyc(29); sync_in = 1; cyc(2); sync_in = 0; cyc(60);
    master = 1; cyc(100); sync_in = 1; cyc(3); sync_in = 0; cyc(100);
    rate = 2'b10; cyc(80); master = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule